// File: doc/BRIEF.md
# Bus Access Permission Checker

This block sits beside the CPU's address path and decides, for every bus access, whether that access may go ahead. The decision uses the processor mode, the address, and three bits taken from the page-map entry that a separate lookup has already fetched. A supervisor-mode access always passes. A user-mode access goes through four checks in a fixed order: I/O space, page not present, kernel region, and write protection. The first check that fails names the fault.

When an access fails, the block pulses a bus-error output and blocks the access. It also records the fault in three readable 16-bit status registers. The general status register holds a code for the fault class, the direction, and whether parity interrupts are enabled. The first bus status register holds the access width and the top byte of the address. The second holds the low half of the address. A write-only clear strobe sets all three registers back to all ones, so software can arm them for the next fault.

Top module: `acc_guard`

## Requirements
- R1: An access with `super_i` high never faults, raises `acc_ok_o`, and leaves all three status registers unchanged, whatever its address or map bits are.
- R2: A user access with address at or above 0x400000 is an I/O-space fault. The highest address below it (0x3FFFFF) is not.
- R3: A user access below 0x400000 whose map bits [1:0] are both zero is a page fault.
- R4: A user access whose address bits [22:19] are all zero is a kernel-region fault.
- R5: A user access whose map bit [2] is zero is a write-protect fault. This applies to reads as well as writes.
- R6: When several checks would fail, the fault taken is the first in this order: I/O space, page fault, kernel region, write protect.
- R7: On a page fault, `gen_stat_o` is loaded with 0x8BFF (write) or 0xCBFF (read). On an I/O-space fault it is loaded with 0x9AFF (write) or 0xDAFF (read). When `par_irq_en_i` is high, bit 10 (0x0400) is also set.
- R8: On any fault, `bus_stat0_o` is loaded with {0x7F, A[23:16]} for a word or long access (`acc_size_i` 01, 10 or 11). For a byte access (`acc_size_i` 00) the upper byte is 0x7D when the address is odd and 0x7E when it is even.
- R9: On any fault, `bus_stat1_o` is loaded with address bits [15:0].
- R10: Reset, or a cycle with `clr_stb_i` high, sets all three status registers to 0xFFFF.
- R11: Kernel-region and write-protect faults do not change `gen_stat_o`.
- R12: The outcome of an access presented with `acc_valid_i` appears in the next cycle as a one-cycle pulse on exactly one of `bus_err_o` and `acc_ok_o`. The status registers change on that same clock edge.
- R13: If a fault and `clr_stb_i` fall in the same cycle, the clear is applied first and the fault then writes its own fields on top of it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | An access is presented this cycle |
| acc_addr_i | input | 24 | Logical address of the access |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_size_i | input | 2 | 00 byte, 01 word, 10 long (11 is treated as long) |
| super_i | input | 1 | Processor is in supervisor mode |
| map_bits_i | input | 3 | Map entry: bit 2 write enable, bits 1:0 page status |
| par_irq_en_i | input | 1 | Parity interrupts enabled |
| clr_stb_i | input | 1 | Clear strobe for the status registers |
| bus_err_o | output | 1 | One-cycle bus-error pulse; the access is blocked |
| acc_ok_o | output | 1 | One-cycle pulse for a granted access |
| gen_stat_o | output | 16 | General status register |
| bus_stat0_o | output | 16 | Bus status register 0 (width code and A[23:16]) |
| bus_stat1_o | output | 16 | Bus status register 1 (A[15:0]) |

## Verification
The assertions check these on every cycle:
- A supervisor access never produces an error.
- The error and grant pulses never occur together.
- The captured low address always matches the faulting access.
- The upper byte of bus status 0 only ever holds one of its four legal values.
- A lone clear strobe leaves all registers at all ones.
- Kernel-region and write-protect faults leave the general status register unchanged.

Only the bench's scenarios can show the rest:
- The exact status codes for each combination of direction and parity-enable.
- The priority when several checks fail at once.
- The boundary address just below I/O space.
- The odd/even byte encoding.
- The clear and fault arriving in the same cycle.

// File: rtl/acc_guard_pkg.sv
package acc_guard_pkg;

  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_USER_IO = 3'd1,
    FLT_PAGE    = 3'd2,
    FLT_KERNEL  = 3'd3,
    FLT_NO_WE   = 3'd4
  } fault_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  localparam int unsigned STAT_W = 16;

  localparam logic [STAT_W-1:0] GS_PAGE_WR = 16'h8BFF;
  localparam logic [STAT_W-1:0] GS_IO_WR   = 16'h9AFF;
  localparam logic [STAT_W-1:0] GS_READ    = 16'h4000;  // read codes = write code | this
  localparam logic [STAT_W-1:0] GS_PARITY  = 16'h0400;
  localparam logic [STAT_W-1:0] STAT_IDLE  = 16'hFFFF;

  localparam logic [7:0] BS0_WIDE = 8'h7F;
  localparam logic [7:0] BS0_ODD  = 8'h7D;
  localparam logic [7:0] BS0_EVEN = 8'h7E;

endpackage

// File: rtl/acc_guard_classify.sv
module acc_guard_classify
  import acc_guard_pkg::*;
#(
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned IO_BASE  = 32'h0040_0000,
  parameter int unsigned KERN_LSB = 19,
  parameter int unsigned KERN_W   = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              super_i,
  input  logic [2:0]        map_bits_i,
  output fault_e            fault_o
);

  localparam logic [ADDR_W-1:0] IO_LIM = ADDR_W'(IO_BASE);

  logic io_hit, page_absent, kern_hit, we_clear;

  assign io_hit      = (addr_i >= IO_LIM);
  assign page_absent = (map_bits_i[1:0] == 2'b00);
  assign kern_hit    = (addr_i[KERN_LSB +: KERN_W] == '0);
  assign we_clear    = ~map_bits_i[2];

  // fixed priority: io, page, kernel, write enable
  always_comb begin
    if (super_i)          fault_o = FLT_NONE;
    else if (io_hit)      fault_o = FLT_USER_IO;
    else if (page_absent) fault_o = FLT_PAGE;
    else if (kern_hit)    fault_o = FLT_KERNEL;
    else if (we_clear)    fault_o = FLT_NO_WE;
    else                  fault_o = FLT_NONE;
  end

endmodule

// File: rtl/acc_guard_status.sv
module acc_guard_status
  import acc_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  fault_e            fault_i,
  input  logic              write_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              par_en_i,
  input  logic              clr_i,
  output logic              err_o,
  output logic              ok_o,
  output logic [STAT_W-1:0] gen_stat_o,
  output logic [STAT_W-1:0] bs0_o,
  output logic [STAT_W-1:0] bs1_o
);

  localparam int unsigned HI_W = ADDR_W - 16;

  logic              is_fault, sets_gen;
  logic [STAT_W-1:0] gen_code, bs0_code;
  logic [7:0]        width_tag;

  assign is_fault = valid_i && (fault_i != FLT_NONE);
  assign sets_gen = (fault_i == FLT_PAGE) || (fault_i == FLT_USER_IO);

  always_comb begin
    gen_code = (fault_i == FLT_PAGE) ? GS_PAGE_WR : GS_IO_WR;
    if (!write_i) gen_code = gen_code | GS_READ;
    if (par_en_i) gen_code = gen_code | GS_PARITY;
  end

  always_comb begin
    if (acc_size_e'(size_i) != SZ_BYTE) width_tag = BS0_WIDE;
    else if (addr_i[0])                 width_tag = BS0_ODD;
    else                                width_tag = BS0_EVEN;
    bs0_code = {width_tag, 8'(addr_i[ADDR_W-1 -: HI_W])};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o      <= 1'b0;
      ok_o       <= 1'b0;
      gen_stat_o <= STAT_IDLE;
      bs0_o      <= STAT_IDLE;
      bs1_o      <= STAT_IDLE;
    end else begin
      err_o <= is_fault;
      ok_o  <= valid_i && !is_fault;
      // clear first, fault fields overlay it
      if (clr_i) begin
        gen_stat_o <= STAT_IDLE;
        bs0_o      <= STAT_IDLE;
        bs1_o      <= STAT_IDLE;
      end
      if (is_fault) begin
        if (sets_gen) gen_stat_o <= gen_code;
        bs0_o <= bs0_code;
        bs1_o <= addr_i[15:0];
      end
    end
  end

  assert_excl_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(err_o && ok_o));

  assert_lo_addr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (bs1_o == $past(addr_i[15:0])));

  assert_bs0_tag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bs0_o[15:8] == BS0_WIDE) || (bs0_o[15:8] == BS0_ODD) ||
    (bs0_o[15:8] == BS0_EVEN) || (bs0_o == STAT_IDLE));

  assert_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !valid_i) |=> (gen_stat_o == STAT_IDLE && bs0_o == STAT_IDLE &&
                             bs1_o == STAT_IDLE));

endmodule

// File: rtl/acc_guard.sv
module acc_guard
  import acc_guard_pkg::*;
#(
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned IO_BASE  = 32'h0040_0000,
  parameter int unsigned KERN_LSB = 19,
  parameter int unsigned KERN_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              acc_write_i,
  input  logic [1:0]        acc_size_i,
  input  logic              super_i,
  input  logic [2:0]        map_bits_i,
  input  logic              par_irq_en_i,
  input  logic              clr_stb_i,
  output logic              bus_err_o,
  output logic              acc_ok_o,
  output logic [15:0]       gen_stat_o,
  output logic [15:0]       bus_stat0_o,
  output logic [15:0]       bus_stat1_o
);

  fault_e fault;

  acc_guard_classify #(
    .ADDR_W  (ADDR_W),
    .IO_BASE (IO_BASE),
    .KERN_LSB(KERN_LSB),
    .KERN_W  (KERN_W)
  ) u_classify (
    .addr_i    (acc_addr_i),
    .super_i   (super_i),
    .map_bits_i(map_bits_i),
    .fault_o   (fault)
  );

  acc_guard_status #(
    .ADDR_W(ADDR_W)
  ) u_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (acc_valid_i),
    .fault_i   (fault),
    .write_i   (acc_write_i),
    .size_i    (acc_size_i),
    .addr_i    (acc_addr_i),
    .par_en_i  (par_irq_en_i),
    .clr_i     (clr_stb_i),
    .err_o     (bus_err_o),
    .ok_o      (acc_ok_o),
    .gen_stat_o(gen_stat_o),
    .bs0_o     (bus_stat0_o),
    .bs1_o     (bus_stat1_o)
  );

  assert_super_pass_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && super_i) |=> (!bus_err_o && acc_ok_o));

  assert_gen_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !clr_stb_i && (fault == FLT_KERNEL || fault == FLT_NO_WE))
      |=> $stable(gen_stat_o));

endmodule

// File: tb/acc_guard_tb.sv
module acc_guard_tb;

  typedef struct packed {
    logic [23:0] addr;
    logic        wr;
    logic [1:0]  size;
    logic        sup;
    logic [2:0]  mb;
    logic        pie;
    logic        err;
    logic [15:0] gs;
    logic [15:0] b0;
    logic [15:0] b1;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    // R1 supervisor, io address, absent page
    '{24'h500000, 1'b1, 2'b10, 1'b1, 3'b000, 1'b0, 1'b0, 16'hFFFF, 16'hFFFF, 16'hFFFF},
    // R2 R7 R8 user read byte odd in io space
    '{24'h400001, 1'b0, 2'b00, 1'b0, 3'b111, 1'b0, 1'b1, 16'hDAFF, 16'h7D40, 16'h0001},
    // R2 R7 R8 user write word
    '{24'hC12346, 1'b1, 2'b01, 1'b0, 3'b111, 1'b0, 1'b1, 16'h9AFF, 16'h7FC1, 16'h2346},
    // R3 R7 R8 page fault write byte even
    '{24'h123456, 1'b1, 2'b00, 1'b0, 3'b100, 1'b0, 1'b1, 16'h8BFF, 16'h7E12, 16'h3456},
    // R3 R6 R7 page fault read long, parity on, kernel region too
    '{24'h0ABCDE, 1'b0, 2'b10, 1'b0, 3'b000, 1'b1, 1'b1, 16'hCFFF, 16'h7F0A, 16'hBCDE},
    // R4 R11 kernel region read word
    '{24'h07FFFE, 1'b0, 2'b01, 1'b0, 3'b111, 1'b0, 1'b1, 16'hFFFF, 16'h7F07, 16'hFFFE},
    // R5 R11 write-protect write byte odd
    '{24'h080001, 1'b1, 2'b00, 1'b0, 3'b011, 1'b0, 1'b1, 16'hFFFF, 16'h7D08, 16'h0001},
    // R5 write-protect on a read
    '{24'h080000, 1'b0, 2'b00, 1'b0, 3'b001, 1'b0, 1'b1, 16'hFFFF, 16'h7E08, 16'h0000},
    // granted user write long
    '{24'h3FFFFC, 1'b1, 2'b10, 1'b0, 3'b111, 1'b0, 1'b0, 16'hFFFF, 16'hFFFF, 16'hFFFF},
    // R6 io beats page fault, parity on, size 11 as long
    '{24'h400000, 1'b1, 2'b11, 1'b0, 3'b000, 1'b1, 1'b1, 16'h9EFF, 16'h7F40, 16'h0000},
    // R2 boundary just below io space
    '{24'h3FFFFF, 1'b0, 2'b00, 1'b0, 3'b110, 1'b0, 1'b0, 16'hFFFF, 16'hFFFF, 16'hFFFF},
    // R1 supervisor kernel address absent page
    '{24'h000000, 1'b0, 2'b00, 1'b1, 3'b000, 1'b0, 1'b0, 16'hFFFF, 16'hFFFF, 16'hFFFF}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [23:0] addr = '0;
  logic        wr = 1'b0;
  logic [1:0]  size = 2'b00;
  logic        sup = 1'b0;
  logic [2:0]  mb = 3'b111;
  logic        pie = 1'b0;
  logic        clr = 1'b0;
  logic        err, ok;
  logic [15:0] gs, b0, b1;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  acc_guard u_dut (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(valid), .acc_addr_i(addr),
    .acc_write_i(wr), .acc_size_i(size), .super_i(sup), .map_bits_i(mb),
    .par_irq_en_i(pie), .clr_stb_i(clr), .bus_err_o(err), .acc_ok_o(ok),
    .gen_stat_o(gs), .bus_stat0_o(b0), .bus_stat1_o(b1)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_clear();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  // result visible at the negedge after the capturing edge
  task automatic do_access(input vec_t v, input logic with_clr);
    @(negedge clk);
    valid = 1'b1; addr = v.addr; wr = v.wr; size = v.size;
    sup = v.sup; mb = v.mb; pie = v.pie; clr = with_clr;
    @(negedge clk);
    valid = 1'b0; clr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 reset gen", {16'h0, gs}, 32'hFFFF);
    chk("R10 reset bs0", {16'h0, b0}, 32'hFFFF);
    chk("R10 reset bs1", {16'h0, b1}, 32'hFFFF);
    chk("R12 reset err", {31'h0, err}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      do_clear();
      do_access(VECS[i], 1'b0);
      chk($sformatf("R12 vec%0d err", i), {31'h0, err}, {31'h0, VECS[i].err});
      chk($sformatf("R12 vec%0d ok", i), {31'h0, ok}, {31'h0, !VECS[i].err});
      chk($sformatf("R7 vec%0d gen", i), {16'h0, gs}, {16'h0, VECS[i].gs});
      chk($sformatf("R8 vec%0d bs0", i), {16'h0, b0}, {16'h0, VECS[i].b0});
      chk($sformatf("R9 vec%0d bs1", i), {16'h0, b1}, {16'h0, VECS[i].b1});
      @(negedge clk);
      chk($sformatf("R12 vec%0d pulse end", i), {30'h0, err, ok}, 32'h0);
    end

    // R11: kernel fault keeps a prior page-fault code
    do_clear();
    do_access(VECS[3], 1'b0);
    do_access(VECS[5], 1'b0);
    chk("R11 gen kept", {16'h0, gs}, 32'h8BFF);
    chk("R11 bs0 updated", {16'h0, b0}, 32'h7F07);

    // R10: clear after a fault
    do_clear();
    @(negedge clk);
    chk("R10 clear gen", {16'h0, gs}, 32'hFFFF);
    chk("R10 clear bs0", {16'h0, b0}, 32'hFFFF);
    chk("R10 clear bs1", {16'h0, b1}, 32'hFFFF);

    // R13: clear and page fault together
    do_access(VECS[2], 1'b0);
    do_access(VECS[3], 1'b1);
    chk("R13 gen fault wins", {16'h0, gs}, 32'h8BFF);
    chk("R13 bs1", {16'h0, b1}, 32'h3456);
    // R13: clear with kernel fault -> gen cleared, bus regs from fault
    do_access(VECS[2], 1'b0);
    do_access(VECS[5], 1'b1);
    chk("R13 gen cleared", {16'h0, gs}, 32'hFFFF);
    chk("R13 bs0", {16'h0, b0}, 32'h7F07);

    // R1: supervisor access leaves captured state untouched
    do_access(VECS[0], 1'b0);
    chk("R1 gen untouched", {16'h0, gs}, 32'hFFFF);
    chk("R1 bs1 untouched", {16'h0, b1}, 32'hFFFE);

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule